// File: doc/BRIEF.md
# Row-Hit Scheduler with Direction Grouping

This block sits between the request intake of a DRAM controller and its per-bank state machines. It keeps every pending request in a queue that belongs to its bank, in the order the requests arrived. Each entry carries a tag, a row, a column and a read/write flag. When a bank state machine needs its next piece of work, it presents the bank, whether a row is open, and which row that is. One cycle later the block returns the tag of the request that bank should serve.

The selection favours requests that hit the open row. Among those hits it prefers ones that travel in the same direction as the last column command that was issued. This keeps reads and writes grouped and reduces bus turnarounds. A hit is passed over when an older hit to the same row and column is still queued, so that two accesses to one address are never reordered. If no hit passes that test, the oldest hit wins. If there is no hit at all, or the bank is closed, the oldest request of the bank wins.

Two look-ahead answers support the auto-precharge decision: whether a bank holds a second request for a given row, and whether it holds a second request at all. Requests enter through a store port and leave through a remove port when their column command issues. Neither port applies back-pressure. A store to a bank whose queue is already full is discarded and reported on `st_drop` in the next cycle, so the upstream buffer accounting must keep a bank from overflowing.

Top module: `rhs_sched`

## Requirements
- R1: Each bank keeps its entries in arrival order. A remove deletes the first entry of the named bank whose tag equals `rm_tag`, from any position, and closes the gap. A remove whose tag matches no entry leaves the queue unchanged.
- R2: When `q_active` is 0, or no entry of the queried bank has a row equal to `q_open_row`, the candidate is the oldest entry of that bank. An empty bank gives `cand_valid` = 0.
- R3: When `q_active` is 1, the candidate is the oldest row hit whose write flag equals the last issued direction and that has no older row hit with the same column.
- R4: When at least one row hit exists but none passes the R3 test, the candidate is the oldest row hit.
- R5: The last issued direction is read (0) after reset. Each remove that matches an entry sets it to that entry's write flag (1 = write). An unmatched remove leaves it unchanged.
- R6: `la_more_hits` is 1 exactly when at least two entries of bank `la_bank` have row `la_row`. The output is combinational on the current state.
- R7: `la_more_reqs` is 1 exactly when bank `la_bank` holds at least two entries. The output is combinational on the current state.
- R8: `cand_valid` and `cand_tag` are registered and reflect the query presented in the previous cycle. `cand_valid` is 0 in the cycle after a cycle without `q_valid`. The query uses the queue contents and the direction as they were before that cycle's store and remove.
- R9: A store and a remove in the same cycle are both applied, the remove first. A store to a bank that held `DEPTH` entries at the start of the cycle is discarded, even if a remove frees a slot in that cycle, and `st_drop` is 1 in the following cycle.
- R10: After reset all queues are empty and `cand_valid`, `st_drop`, `la_more_hits` and `la_more_reqs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store a new request this cycle |
| st_bank | input | BANK_W | Bank of the stored request |
| st_tag | input | TAG_W | Tag of the stored request |
| st_row | input | ROW_W | Row of the stored request |
| st_col | input | COL_W | Column of the stored request |
| st_wr | input | 1 | 1 = write, 0 = read |
| st_drop | output | 1 | Previous cycle's store was discarded because the queue was full |
| rm_valid | input | 1 | Remove a request this cycle |
| rm_bank | input | BANK_W | Bank of the removed request |
| rm_tag | input | TAG_W | Tag of the removed request |
| q_valid | input | 1 | Candidate query this cycle |
| q_bank | input | BANK_W | Queried bank |
| q_active | input | 1 | Queried bank has an open row |
| q_open_row | input | ROW_W | Open row of the queried bank |
| cand_valid | output | 1 | Registered: candidate exists for last cycle's query |
| cand_tag | output | TAG_W | Registered: tag of that candidate |
| la_bank | input | BANK_W | Bank for look-ahead answers |
| la_row | input | ROW_W | Row for the further-hit answer |
| la_more_hits | output | 1 | At least two entries of `la_bank` target `la_row` |
| la_more_reqs | output | 1 | `la_bank` holds at least two entries |

## Verification
Directed cases first separate the selection tiers. A closed bank, and an open bank with no hit, both return the oldest entry. A read hit queued behind an older write hit shows that reset leaves the direction at read. A same-address pair followed by a younger hit shows the hazard skip, and removing the younger hit shows the fall-back to the oldest hit. Further directed cycles fill a bank to its depth, store while removing from a full bank, and remove an absent tag, which separates the order of same-cycle updates from the overflow rule. A long stretch of constrained-random traffic follows, with rows and columns drawn from tiny ranges so that hits, direction matches and address hazards occur often. In that stretch the registered candidate and both look-ahead answers are compared every cycle against a queue model in the bench.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/rhs_bank_queue.sv
module rhs_bank_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_en,
  input  logic [TAG_W-1:0] st_tag,
  input  logic [ROW_W-1:0] st_row,
  input  logic [COL_W-1:0] st_col,
  input  logic             st_wr,
  input  logic             rm_en,
  input  logic [TAG_W-1:0] rm_tag,
  output logic [TAG_W-1:0] tag_o [DEPTH],
  output logic [ROW_W-1:0] row_o [DEPTH],
  output logic [COL_W-1:0] col_o [DEPTH],
  output logic             wr_o  [DEPTH],
  output logic [CNT_W-1:0] cnt_o,
  output logic             rm_hit_o,
  output logic             rm_wr_o,
  output logic             st_drop_o
);
  logic [TAG_W-1:0] tag_q [DEPTH], tag_n [DEPTH];
  logic [ROW_W-1:0] row_q [DEPTH], row_n [DEPTH];
  logic [COL_W-1:0] col_q [DEPTH], col_n [DEPTH];
  logic             wr_q  [DEPTH], wr_n  [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n, cut_idx;

  // locate the first entry carrying the removal tag
  always_comb begin
    rm_hit_o = 1'b0;
    rm_wr_o  = 1'b0;
    cut_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!rm_hit_o && (CNT_W'(i) < cnt_q) && (tag_q[i] == rm_tag)) begin
        rm_hit_o = 1'b1;
        rm_wr_o  = wr_q[i];
        cut_idx  = CNT_W'(i);
      end
    end
  end

  assign st_drop_o = st_en && (cnt_q == CNT_W'(DEPTH));

  // removal compacts first, the store then appends behind the survivors
  always_comb begin
    tag_n = tag_q;
    row_n = row_q;
    col_n = col_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (rm_en && rm_hit_o) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (CNT_W'(i) >= cut_idx) begin
          tag_n[i] = tag_q[i+1];
          row_n[i] = row_q[i+1];
          col_n[i] = col_q[i+1];
          wr_n[i]  = wr_q[i+1];
        end
      end
      cnt_n = cnt_q - 1'b1;
    end
    if (st_en && !st_drop_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_n) begin
          tag_n[i] = st_tag;
          row_n[i] = st_row;
          col_n[i] = st_col;
          wr_n[i]  = st_wr;
        end
      end
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        row_q[i] <= '0;
        col_q[i] <= '0;
        wr_q[i]  <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_n;
      tag_q <= tag_n;
      row_q <= row_n;
      col_q <= col_n;
      wr_q  <= wr_n;
    end
  end

  assign tag_o = tag_q;
  assign row_o = row_q;
  assign col_o = col_q;
  assign wr_o  = wr_q;
  assign cnt_o = cnt_q;

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && cnt_q == CNT_W'(DEPTH)) |=> (cnt_q == CNT_W'(DEPTH) - CNT_W'($past(rm_en && rm_hit_o))));
  p_store_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && cnt_q < CNT_W'(DEPTH) && !(rm_en && rm_hit_o)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_remove_shrink_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_en && rm_hit_o && !st_en) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_miss_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_en && !(rm_en && rm_hit_o)) |=> $stable(cnt_q));
endmodule

// File: rtl/rhs_pick.sv
module rhs_pick #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [TAG_W-1:0] tag_i [DEPTH],
  input  logic [ROW_W-1:0] row_i [DEPTH],
  input  logic [COL_W-1:0] col_i [DEPTH],
  input  logic             wr_i  [DEPTH],
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             active_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             last_wr_i,
  output logic             found_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [DEPTH-1:0] hit, pass;
  logic             haz, got_pass, got_hit;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = (CNT_W'(i) < cnt_i) && active_i && (row_i[i] == open_row_i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      haz = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && hit[j] && col_i[j] == col_i[i]) haz = 1'b1;
      end
      pass[i] = hit[i] && (wr_i[i] == last_wr_i) && !haz;
    end
  end

  // tiered choice: grouped hit, then oldest hit, then oldest entry
  always_comb begin
    got_pass = 1'b0;
    got_hit  = 1'b0;
    found_o  = (cnt_i != '0);
    tag_o    = (cnt_i != '0) ? tag_i[0] : '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!got_hit && hit[i]) begin
        got_hit = 1'b1;
        tag_o   = tag_i[i];
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (!got_pass && pass[i]) begin
        got_pass = 1'b1;
        tag_o    = tag_i[i];
      end
    end
  end
endmodule

// File: rtl/rhs_sched.sv
module rhs_sched #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 4,
  parameter int TAG_W     = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [BANK_W-1:0] st_bank,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [ROW_W-1:0]  st_row,
  input  logic [COL_W-1:0]  st_col,
  input  logic              st_wr,
  output logic              st_drop,
  input  logic              rm_valid,
  input  logic [BANK_W-1:0] rm_bank,
  input  logic [TAG_W-1:0]  rm_tag,
  input  logic              q_valid,
  input  logic [BANK_W-1:0] q_bank,
  input  logic              q_active,
  input  logic [ROW_W-1:0]  q_open_row,
  output logic              cand_valid,
  output logic [TAG_W-1:0]  cand_tag,
  input  logic [BANK_W-1:0] la_bank,
  input  logic [ROW_W-1:0]  la_row,
  output logic              la_more_hits,
  output logic              la_more_reqs
);
  import rhs_pkg::*;

  logic [TAG_W-1:0] b_tag [NUM_BANKS][DEPTH];
  logic [ROW_W-1:0] b_row [NUM_BANKS][DEPTH];
  logic [COL_W-1:0] b_col [NUM_BANKS][DEPTH];
  logic             b_wr  [NUM_BANKS][DEPTH];
  logic [CNT_W-1:0] b_cnt [NUM_BANKS];
  logic [NUM_BANKS-1:0] b_rm_hit, b_rm_wr, b_drop;

  dir_e last_dir;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rhs_bank_queue #(
      .DEPTH(DEPTH), .TAG_W(TAG_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_en    (st_valid && st_bank == BANK_W'(b)),
      .st_tag   (st_tag),
      .st_row   (st_row),
      .st_col   (st_col),
      .st_wr    (st_wr),
      .rm_en    (rm_valid && rm_bank == BANK_W'(b)),
      .rm_tag   (rm_tag),
      .tag_o    (b_tag[b]),
      .row_o    (b_row[b]),
      .col_o    (b_col[b]),
      .wr_o     (b_wr[b]),
      .cnt_o    (b_cnt[b]),
      .rm_hit_o (b_rm_hit[b]),
      .rm_wr_o  (b_rm_wr[b]),
      .st_drop_o(b_drop[b])
    );
  end

  // bring the queried bank's queue to the picker
  logic [TAG_W-1:0] s_tag [DEPTH];
  logic [ROW_W-1:0] s_row [DEPTH];
  logic [COL_W-1:0] s_col [DEPTH];
  logic             s_wr  [DEPTH];
  logic             pick_found;
  logic [TAG_W-1:0] pick_tag;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      s_tag[i] = b_tag[q_bank][i];
      s_row[i] = b_row[q_bank][i];
      s_col[i] = b_col[q_bank][i];
      s_wr[i]  = b_wr[q_bank][i];
    end
  end

  rhs_pick #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pick (
    .tag_i     (s_tag),
    .row_i     (s_row),
    .col_i     (s_col),
    .wr_i      (s_wr),
    .cnt_i     (b_cnt[q_bank]),
    .active_i  (q_active),
    .open_row_i(q_open_row),
    .last_wr_i (last_dir == DIR_WR),
    .found_o   (pick_found),
    .tag_o     (pick_tag)
  );

  logic rm_taken;
  assign rm_taken = rm_valid && b_rm_hit[rm_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_dir   <= DIR_RD;
      cand_valid <= 1'b0;
      cand_tag   <= '0;
      st_drop    <= 1'b0;
    end else begin
      if (rm_taken) last_dir <= b_rm_wr[rm_bank] ? DIR_WR : DIR_RD;
      cand_valid <= q_valid && pick_found;
      cand_tag   <= (q_valid && pick_found) ? pick_tag : '0;
      st_drop    <= st_valid && b_drop[st_bank];
    end
  end

  // look-ahead answers for the auto-precharge decision
  logic [CNT_W-1:0] la_hits;
  always_comb begin
    la_hits = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < b_cnt[la_bank] && b_row[la_bank][i] == la_row) la_hits = la_hits + 1'b1;
    end
  end
  assign la_more_hits = (la_hits >= CNT_W'(2));
  assign la_more_reqs = (b_cnt[la_bank] >= CNT_W'(2));

  p_cand_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !cand_valid);
  p_empty_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && b_cnt[q_bank] == '0) |=> !cand_valid);
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rm_taken |=> $stable(last_dir));
  p_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_drop) |-> $past(st_valid));
  p_hits_need_reqs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    la_more_hits |-> la_more_reqs);
endmodule

// File: tb/rhs_sched_tb.sv
`timescale 1ns/1ps
module rhs_sched_tb;
  localparam int NB = 4;
  localparam int D  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic st_valid = 0, st_wr = 0, rm_valid = 0, q_valid = 0, q_active = 0;
  logic [1:0] st_bank = 0, rm_bank = 0, q_bank = 0, la_bank = 0;
  logic [3:0] st_tag = 0, rm_tag = 0;
  logic [7:0] st_row = 0, q_open_row = 0, la_row = 0;
  logic [5:0] st_col = 0;
  logic st_drop, cand_valid, la_more_hits, la_more_reqs;
  logic [3:0] cand_tag;

  rhs_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_bank(st_bank), .st_tag(st_tag), .st_row(st_row),
    .st_col(st_col), .st_wr(st_wr), .st_drop(st_drop),
    .rm_valid(rm_valid), .rm_bank(rm_bank), .rm_tag(rm_tag),
    .q_valid(q_valid), .q_bank(q_bank), .q_active(q_active), .q_open_row(q_open_row),
    .cand_valid(cand_valid), .cand_tag(cand_tag),
    .la_bank(la_bank), .la_row(la_row), .la_more_hits(la_more_hits), .la_more_reqs(la_more_reqs)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference queues
  int mtag [NB][D];
  int mrow [NB][D];
  int mcol [NB][D];
  bit mwr  [NB][D];
  int mcnt [NB];
  bit mdir;

  // next-step stimulus
  bit n_st, n_wr, n_rm, n_q, n_act;
  int n_sb, n_tag, n_row, n_col, n_rb, n_rtag, n_qb, n_orow, n_lb, n_lrow;
  bit pend = 0, e_v = 0, e_drop = 0;
  int e_t = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    n_st = 0; n_rm = 0; n_q = 0; n_act = 0; n_wr = 0;
    n_sb = 0; n_tag = 0; n_row = 0; n_col = 0; n_rb = 0; n_rtag = 0;
    n_qb = 0; n_orow = 0; n_lb = 0; n_lrow = 0;
  endtask

  function automatic void mpick(input int b, input bit act, input int orow,
                                output bit v, output int t);
    int first_hit;
    v = (mcnt[b] > 0);
    t = v ? mtag[b][0] : 0;
    first_hit = -1;
    for (int i = 0; i < mcnt[b]; i++)
      if (act && mrow[b][i] == orow && first_hit < 0) first_hit = i;
    if (first_hit >= 0) t = mtag[b][first_hit];
    for (int i = 0; i < mcnt[b]; i++) begin
      bit older_same;
      older_same = 0;
      if (!(act && mrow[b][i] == orow)) continue;
      for (int j = 0; j < i; j++)
        if (mrow[b][j] == orow && mcol[b][j] == mcol[b][i]) older_same = 1;
      if (mwr[b][i] == mdir && !older_same) begin
        t = mtag[b][i];
        break;
      end
    end
  endfunction

  task automatic step();
    int hits;
    @(negedge clk);
    if (pend) begin
      chk("R8 cand_valid (R2 R3 R4)", cand_valid, e_v);
      if (e_v) chk("R3 R4 R2 cand_tag", cand_tag, e_t);
      chk("R9 st_drop", st_drop, e_drop);
    end
    st_valid = n_st; st_bank = n_sb[1:0]; st_tag = n_tag[3:0]; st_row = n_row[7:0];
    st_col = n_col[5:0]; st_wr = n_wr;
    rm_valid = n_rm; rm_bank = n_rb[1:0]; rm_tag = n_rtag[3:0];
    q_valid = n_q; q_bank = n_qb[1:0]; q_active = n_act; q_open_row = n_orow[7:0];
    la_bank = n_lb[1:0]; la_row = n_lrow[7:0];
    #1;
    hits = 0;
    for (int i = 0; i < mcnt[n_lb]; i++) if (mrow[n_lb][i] == n_lrow) hits++;
    chk("R6 la_more_hits", la_more_hits, (hits >= 2));
    chk("R7 la_more_reqs", la_more_reqs, (mcnt[n_lb] >= 2));
    if (n_q) mpick(n_qb, n_act, n_orow, e_v, e_t);
    else begin e_v = 0; e_t = 0; end
    e_drop = n_st && (mcnt[n_sb] == D);
    if (n_rm) begin
      int k;
      k = -1;
      for (int i = 0; i < mcnt[n_rb]; i++) if (k < 0 && mtag[n_rb][i] == n_rtag) k = i;
      if (k >= 0) begin
        mdir = mwr[n_rb][k];
        for (int i = k; i < D - 1; i++) begin
          mtag[n_rb][i] = mtag[n_rb][i+1]; mrow[n_rb][i] = mrow[n_rb][i+1];
          mcol[n_rb][i] = mcol[n_rb][i+1]; mwr[n_rb][i]  = mwr[n_rb][i+1];
        end
        mcnt[n_rb]--;
      end
    end
    if (n_st && !e_drop) begin
      mtag[n_sb][mcnt[n_sb]] = n_tag; mrow[n_sb][mcnt[n_sb]] = n_row;
      mcol[n_sb][mcnt[n_sb]] = n_col; mwr[n_sb][mcnt[n_sb]]  = n_wr;
      mcnt[n_sb]++;
    end
    pend = 1;
  endtask

  task automatic put(input int b, input int tg, input int r, input int c, input bit w);
    clr(); n_st = 1; n_sb = b; n_tag = tg; n_row = r; n_col = c; n_wr = w; step();
  endtask

  task automatic ask(input int b, input bit act, input int r);
    clr(); n_q = 1; n_qb = b; n_act = act; n_orow = r; n_lb = b; n_lrow = r; step();
  endtask

  task automatic take(input int b, input int tg);
    clr(); n_rm = 1; n_rb = b; n_rtag = tg; step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9173));
    for (int b = 0; b < NB; b++) mcnt[b] = 0;
    mdir = 0;
    clr();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cand_valid after reset", cand_valid, 0);
    chk("R10 st_drop after reset", st_drop, 0);
    chk("R10 la_more_reqs after reset", la_more_reqs, 0);
    chk("R10 la_more_hits after reset", la_more_hits, 0);

    // R2 empty bank gives nothing
    ask(3, 1, 0);
    // R5: write hit older than read hit, direction starts at read
    put(0, 1, 1, 0, 1);
    put(0, 2, 1, 1, 0);
    ask(0, 1, 1);           // expect tag 2
    ask(0, 0, 1);           // R2 precharged: expect tag 1
    ask(0, 1, 9);           // R2 no hit: expect tag 1
    take(0, 7);             // R1 unmatched tag: no change
    ask(0, 0, 0);           // still tag 1 oldest
    take(0, 2);             // R5 direction -> read
    put(0, 3, 1, 2, 0);
    take(0, 1);             // R5 direction -> write
    put(0, 4, 1, 3, 1);
    ask(0, 1, 1);           // write hit tag 4 over older read 3
    // R3 hazard: write A, read B same addr, read C
    put(1, 5, 2, 3, 1);
    take(0, 3);             // direction read
    put(1, 6, 2, 3, 0);
    put(1, 8, 2, 5, 0);
    ask(1, 1, 2);           // expect tag 8
    take(1, 8);             // direction read
    ask(1, 1, 2);           // R4 no pass: expect oldest hit tag 5
    // R9 fill bank 2 then overflow
    put(2, 9, 4, 0, 0);
    put(2, 10, 4, 1, 0);
    put(2, 11, 5, 0, 1);
    put(2, 12, 4, 2, 1);
    put(2, 13, 4, 3, 0);    // dropped
    clr(); n_st = 1; n_sb = 2; n_tag = 14; n_row = 6; n_rm = 1; n_rb = 2; n_rtag = 10; step();
    clr(); n_st = 1; n_sb = 2; n_tag = 15; n_row = 6; n_rm = 1; n_rb = 2; n_rtag = 9; step();
    ask(2, 1, 6);           // R9 tag 15 present after remove-then-store
    ask(2, 1, 4);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int tg_next;
      clr();
      tg_next = n % 16;
      if ($urandom_range(0, 99) < 45) begin
        n_st = 1; n_sb = $urandom_range(0, NB - 1); n_tag = tg_next;
        n_row = $urandom_range(0, 2); n_col = $urandom_range(0, 1); n_wr = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 99) < 40) begin
        n_rm = 1; n_rb = $urandom_range(0, NB - 1);
        if (mcnt[n_rb] > 0 && $urandom_range(0, 3) != 0)
          n_rtag = mtag[n_rb][$urandom_range(0, mcnt[n_rb] - 1)];
        else n_rtag = $urandom_range(0, 15);
      end
      if ($urandom_range(0, 99) < 70) begin
        n_q = 1; n_qb = $urandom_range(0, NB - 1); n_act = $urandom_range(0, 3) != 0;
        n_orow = $urandom_range(0, 2);
      end
      n_lb = $urandom_range(0, NB - 1); n_lrow = $urandom_range(0, 2);
      step();
    end
    clr();
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule